// File: doc/BRIEF.md
# Channel Energy Detector with Strongest-Channel Capture

This block sits behind a channelizer that emits one complex sample per narrowband channel in a fixed round-robin sweep. For every sample it forms the instantaneous power I² + Q² and compares it against a running power estimate kept separately for that channel. A sample whose power exceeds a programmable multiple of its own channel's estimate marks the current sweep as containing a signal.

At the close of each sweep the block knows which channel carried the highest power. If any channel in that sweep crossed its threshold and no capture is running, that channel is locked as the capture target. From the next sweep on, the target channel's raw I/Q samples are streamed out as a fixed-length packet on a stream master, tagged with the channel index and closed with a last marker. While a packet is running, the per-channel estimates are held so that the pulse being captured does not raise its own threshold.

Top module: `chan_energy_detect`

## Requirements
- R1: Power is I² + Q² of the 16-bit signed inputs, held without loss at 33 bits, so full-scale inputs of -32768 on both rails (2³¹) compare correctly against smaller powers.
- R2: Each channel keeps an exponential average with weight 1/16: new = old − old/16 + power/16 (shifts truncate). The sweep right after reset loads every average with that sweep's power and cannot produce a detection.
- R3: A sample is a hit when its power is strictly greater than the channel average shifted left by `thr_log2` (K = 2^thr_log2; a setting of 3 gives K = 8). Equality is not a hit.
- R4: While a capture packet is in progress no channel average changes.
- R5: At the last channel of a sweep, if any sample of that sweep was a hit and no packet is running, the channel with the highest power in the sweep is selected; equal powers go to the lowest channel index.
- R6: Capture starts with the following sweep: each sweep yields one beat holding the selected channel's sample, with `m_tdata[15:0]` = I and `m_tdata[31:16]` = Q.
- R7: A packet is exactly PKT_LEN beats (default 1024); `m_tlast` is high on the final beat only, and `m_tuser` carries the selected channel index, constant over the packet.
- R8: Hits in sweeps that end while a packet is running do not start or redirect a capture.
- R9: Cycles with `s_valid` low are ignored whatever the sample inputs carry; the first valid sample after reset is channel 0, and channels advance by one per valid sample, wrapping after N_CH − 1.
- R10: During and right after reset `m_tvalid` and `m_tlast` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_log2 | input | 3 | Threshold multiplier exponent, K = 2^thr_log2 |
| s_valid | input | 1 | Input sample valid |
| s_i | input | 16 | Input in-phase sample, signed |
| s_q | input | 16 | Input quadrature sample, signed |
| m_tvalid | output | 1 | Output stream beat valid |
| m_tdata | output | 32 | Captured sample, Q in upper half, I in lower half |
| m_tlast | output | 1 | Final beat of a packet |
| m_tuser | output | 6 | Index of the captured channel |

## Verification
The bench walks threshold edges in both directions (a power one step above and exactly at K times the average), ties between channels, the first and last channel as winners, and full-scale inputs; a comparator using `>=`, a narrowed power sum or a reversed tie rule would select the wrong channel or emit a packet where none is due. Separate sequences check the 1/16 averaging weight through a power level that detects only under the right weight, the seeding sweep after reset, and the freeze of the averages during capture: a design that kept updating during a packet would miss the follow-up detection. Idle cycles loaded with full-scale garbage are interleaved within sweeps, so a design that sampled them would shift channel indices and tag the wrong channel.

// File: rtl/ced_pkg.sv
package ced_pkg;
   localparam int THR_W = 3;
   typedef enum logic {CAP_IDLE, CAP_RUN} cap_state_e;
endpackage

// File: rtl/ced_power.sv
module ced_power #(
   parameter int DW   = 16,
   parameter int N_CH = 64,
   parameter int CW   = 6,
   parameter int PW   = 33
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 s_valid,
   input  logic signed [DW-1:0] s_i,
   input  logic signed [DW-1:0] s_q,
   output logic                 p_valid,
   output logic [CW-1:0]        p_chan,
   output logic [PW-1:0]        p_pow,
   output logic signed [DW-1:0] p_i,
   output logic signed [DW-1:0] p_q
);
   logic signed [2*DW-1:0] sq_i, sq_q;
   logic [CW-1:0]          ch_cnt;

   assign sq_i = s_i * s_i;
   assign sq_q = s_q * s_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         p_valid <= 1'b0;
         p_chan  <= '0;
         p_pow   <= '0;
         p_i     <= '0;
         p_q     <= '0;
         ch_cnt  <= '0;
      end else begin
         p_valid <= s_valid;
         if (s_valid) begin
            p_chan <= ch_cnt;
            p_pow  <= {1'b0, sq_i} + {1'b0, sq_q};
            p_i    <= s_i;
            p_q    <= s_q;
            ch_cnt <= (ch_cnt == CW'(N_CH-1)) ? '0 : ch_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/ced_avg_bank.sv
module ced_avg_bank
   import ced_pkg::*;
#(
   parameter int N_CH      = 64,
   parameter int CW        = 6,
   parameter int PW        = 33,
   parameter int AVG_SHIFT = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             p_valid,
   input  logic [CW-1:0]    p_chan,
   input  logic [PW-1:0]    p_pow,
   input  logic [THR_W-1:0] thr_log2,
   input  logic             busy,
   output logic             hit
);
   localparam int TW = PW + (1 << THR_W) - 1;

   logic [PW-1:0] avg_r [N_CH];
   logic [PW-1:0] avg_rd, avg_nx;
   logic [TW-1:0] limit;
   logic          primed, upd;

   always_comb begin
      avg_rd = avg_r[p_chan];
      limit  = TW'(avg_rd) << thr_log2;
      hit    = primed && p_valid && (TW'(p_pow) > limit);
      avg_nx = primed ? (avg_rd - (avg_rd >> AVG_SHIFT) + (p_pow >> AVG_SHIFT)) : p_pow;
      upd    = p_valid && !busy;
   end

   for (genvar g = 0; g < N_CH; g++) begin : g_ch
      logic [PW-1:0] acc;
      always_ff @(posedge clk) begin
         if (rst)
            acc <= '0;
         else if (upd && p_chan == CW'(g))
            acc <= avg_nx;
      end
      assign avg_r[g] = acc;
   end

   always_ff @(posedge clk) begin
      if (rst)
         primed <= 1'b0;
      else if (p_valid && p_chan == CW'(N_CH-1))
         primed <= 1'b1;
   end
endmodule

// File: rtl/ced_argmax.sv
module ced_argmax #(
   parameter int N_CH = 64,
   parameter int CW   = 6,
   parameter int PW   = 33
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          p_valid,
   input  logic [CW-1:0] p_chan,
   input  logic [PW-1:0] p_pow,
   input  logic          hit,
   output logic          fin,
   output logic          fin_hit,
   output logic [CW-1:0] fin_idx
);
   logic [PW-1:0] best_pow, nb_pow;
   logic [CW-1:0] best_idx, nb_idx;
   logic          any_hit, n_any, first, take;

   always_comb begin
      first  = (p_chan == '0);
      take   = first || (p_pow > best_pow);
      nb_pow = take ? p_pow  : best_pow;
      nb_idx = take ? p_chan : best_idx;
      n_any  = (first ? 1'b0 : any_hit) | hit;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         best_pow <= '0;
         best_idx <= '0;
         any_hit  <= 1'b0;
      end else if (p_valid) begin
         best_pow <= nb_pow;
         best_idx <= nb_idx;
         any_hit  <= n_any;
      end
   end

   assign fin     = p_valid && (p_chan == CW'(N_CH-1));
   assign fin_hit = n_any;
   assign fin_idx = nb_idx;
endmodule

// File: rtl/ced_capture.sv
module ced_capture
   import ced_pkg::*;
#(
   parameter int DW      = 16,
   parameter int CW      = 6,
   parameter int PKT_LEN = 1024
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 p_valid,
   input  logic [CW-1:0]        p_chan,
   input  logic signed [DW-1:0] p_i,
   input  logic signed [DW-1:0] p_q,
   input  logic                 start,
   input  logic [CW-1:0]        fin_idx,
   output logic                 busy,
   output logic                 m_tvalid,
   output logic [2*DW-1:0]      m_tdata,
   output logic                 m_tlast,
   output logic [CW-1:0]        m_tuser
);
   localparam int KW = (PKT_LEN > 1) ? $clog2(PKT_LEN) : 1;

   cap_state_e    state;
   logic [CW-1:0] sel;
   logic [KW-1:0] cnt;
   logic          at_end;

   assign at_end  = (cnt == KW'(PKT_LEN-1));
   assign busy    = (state == CAP_RUN);
   assign m_tuser = sel;

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= CAP_IDLE;
         sel      <= '0;
         cnt      <= '0;
         m_tvalid <= 1'b0;
         m_tlast  <= 1'b0;
         m_tdata  <= '0;
      end else begin
         m_tvalid <= 1'b0;
         m_tlast  <= 1'b0;
         case (state)
            CAP_IDLE: begin
               if (start) begin
                  state <= CAP_RUN;
                  sel   <= fin_idx;
                  cnt   <= '0;
               end
            end
            CAP_RUN: begin
               if (p_valid && p_chan == sel) begin
                  m_tvalid <= 1'b1;
                  m_tdata  <= {p_q, p_i};
                  m_tlast  <= at_end;
                  if (at_end) state <= CAP_IDLE;
                  else        cnt   <= cnt + 1'b1;
               end
            end
            default: state <= CAP_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/chan_energy_detect.sv
module chan_energy_detect
   import ced_pkg::*;
#(
   parameter int N_CH      = 64,
   parameter int DW        = 16,
   parameter int AVG_SHIFT = 4,
   parameter int PKT_LEN   = 1024,
   localparam int CW       = (N_CH > 1) ? $clog2(N_CH) : 1,
   localparam int PW       = 2*DW + 1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [THR_W-1:0]     thr_log2,
   input  logic                 s_valid,
   input  logic signed [DW-1:0] s_i,
   input  logic signed [DW-1:0] s_q,
   output logic                 m_tvalid,
   output logic [2*DW-1:0]      m_tdata,
   output logic                 m_tlast,
   output logic [CW-1:0]        m_tuser
);
   if (N_CH < 2) begin : g_bad_nch
      $error("N_CH must be at least 2");
   end
   if (DW < 2) begin : g_bad_dw
      $error("DW must be at least 2");
   end
   if (PKT_LEN < 1) begin : g_bad_len
      $error("PKT_LEN must be at least 1");
   end
   if (AVG_SHIFT < 1 || AVG_SHIFT >= PW) begin : g_bad_shift
      $error("AVG_SHIFT out of range");
   end

   logic                 p_valid, hit, fin, fin_hit, busy, start;
   logic [CW-1:0]        p_chan, fin_idx;
   logic [PW-1:0]        p_pow;
   logic signed [DW-1:0] p_i, p_q;

   ced_power #(.DW(DW), .N_CH(N_CH), .CW(CW), .PW(PW)) u_power (
      .clk(clk), .rst(rst), .s_valid(s_valid), .s_i(s_i), .s_q(s_q),
      .p_valid(p_valid), .p_chan(p_chan), .p_pow(p_pow), .p_i(p_i), .p_q(p_q)
   );

   ced_avg_bank #(.N_CH(N_CH), .CW(CW), .PW(PW), .AVG_SHIFT(AVG_SHIFT)) u_avg (
      .clk(clk), .rst(rst), .p_valid(p_valid), .p_chan(p_chan), .p_pow(p_pow),
      .thr_log2(thr_log2), .busy(busy), .hit(hit)
   );

   ced_argmax #(.N_CH(N_CH), .CW(CW), .PW(PW)) u_argmax (
      .clk(clk), .rst(rst), .p_valid(p_valid), .p_chan(p_chan), .p_pow(p_pow),
      .hit(hit), .fin(fin), .fin_hit(fin_hit), .fin_idx(fin_idx)
   );

   assign start = fin && fin_hit && !busy;

   ced_capture #(.DW(DW), .CW(CW), .PKT_LEN(PKT_LEN)) u_capture (
      .clk(clk), .rst(rst), .p_valid(p_valid), .p_chan(p_chan), .p_i(p_i), .p_q(p_q),
      .start(start), .fin_idx(fin_idx), .busy(busy),
      .m_tvalid(m_tvalid), .m_tdata(m_tdata), .m_tlast(m_tlast), .m_tuser(m_tuser)
   );
endmodule

// File: rtl/ced_checker.sv
module ced_checker #(
   parameter int PKT_LEN = 1024,
   parameter int CW      = 6
) (
   input logic          clk,
   input logic          rst,
   input logic          m_tvalid,
   input logic          m_tlast,
   input logic [CW-1:0] m_tuser
);
   localparam int BW = $clog2(PKT_LEN + 1);

   logic [BW-1:0] beats;

   always_ff @(posedge clk) begin
      if (rst)
         beats <= '0;
      else if (m_tvalid)
         beats <= m_tlast ? '0 : beats + 1'b1;
   end

   a_r10_reset_quiet: assert property (@(posedge clk)
      rst |=> (!m_tvalid && !m_tlast));

   a_r7_last_needs_valid: assert property (@(posedge clk) disable iff (rst)
      m_tlast |-> m_tvalid);

   a_r7_last_at_count: assert property (@(posedge clk) disable iff (rst)
      m_tvalid |-> (m_tlast == (beats == BW'(PKT_LEN-1))));

   a_r7_tuser_held: assert property (@(posedge clk) disable iff (rst)
      (m_tvalid && !m_tlast) |=> $stable(m_tuser));
endmodule

bind chan_energy_detect ced_checker #(.PKT_LEN(PKT_LEN), .CW(CW)) u_ced_checker (
   .clk(clk), .rst(rst), .m_tvalid(m_tvalid), .m_tlast(m_tlast), .m_tuser(m_tuser)
);

// File: tb/chan_energy_detect_bench.sv
module chan_energy_detect_bench;
   localparam int N_CH    = 8;
   localparam int PKT_LEN = 4;
   localparam int NV      = 10;
   // fields: thr_log2, chanA, ampA, chanB (-1 none), ampB, expect_detect, expect_index
   localparam int VEC [NV][7] = '{
      '{3, 3,    129, -1,     0, 1, 3},   // R3: just above 8 x average
      '{3, 3,    128, -1,     0, 0, 0},   // R3: exactly at threshold
      '{3, 1,    200,  6,   200, 1, 1},   // R5: tie to lowest index
      '{3, 4,    150,  6,   180, 1, 6},   // R5: stronger channel wins
      '{1, 2,     65, -1,     0, 1, 2},   // R3: K = 2 above
      '{1, 2,     64, -1,     0, 0, 0},   // R3: K = 2 at threshold
      '{3, 7,    129, -1,     0, 1, 7},   // R5: last channel
      '{3, 0,    129, -1,     0, 1, 0},   // R5: first channel
      '{3, 2, -32768,  5, 32767, 1, 2},   // R1: full-scale power compare
      '{0, 4,     46, -1,     0, 1, 4}    // R3: K = 1
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  thr_log2 = 3'd3;
   logic        s_valid = 1'b0;
   logic signed [15:0] s_i = '0, s_q = '0;
   logic        m_tvalid, m_tlast;
   logic [31:0] m_tdata;
   logic [2:0]  m_tuser;

   int total = 0;
   int bad   = 0;
   int nb    = 0;
   logic signed [15:0] bi [64];
   logic signed [15:0] bq [64];
   logic [2:0]         bu [64];
   logic               bl [64];

   always #10 clk = ~clk;

   chan_energy_detect #(.N_CH(N_CH), .PKT_LEN(PKT_LEN)) u_chan_energy_detect (
      .clk(clk), .rst(rst), .thr_log2(thr_log2), .s_valid(s_valid), .s_i(s_i), .s_q(s_q),
      .m_tvalid(m_tvalid), .m_tdata(m_tdata), .m_tlast(m_tlast), .m_tuser(m_tuser)
   );

   always @(negedge clk) begin
      if (rst) nb = 0;
      else if (m_tvalid) begin
         if (nb < 64) begin
            bi[nb] = m_tdata[15:0];
            bq[nb] = m_tdata[31:16];
            bu[nb] = m_tuser;
            bl[nb] = m_tlast;
         end
         nb = nb + 1;
      end
   end

   task automatic chk(input bit ok, input string what, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic put(input int i, input int q);
      @(negedge clk);
      s_valid = 1'b1;
      s_i = 16'(i);
      s_q = 16'(q);
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         s_valid = 1'b0;
         s_i = 16'sh7fff;
         s_q = 16'sh7fff;
      end
   endtask

   task automatic do_reset(input int k);
      @(negedge clk);
      rst = 1'b1;
      s_valid = 1'b0;
      thr_log2 = 3'(k);
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic bg_frame();
      for (int c = 0; c < N_CH; c++) put(64, 0);
   endtask

   task automatic spike_frame(input int ca, input int aa, input int cb, input int ab, input bit gaps);
      for (int c = 0; c < N_CH; c++) begin
         if (c == ca)      put(aa, aa);
         else if (c == cb) put(ab, ab);
         else              put(64, 0);
         if (gaps) idle(1);   // R9: garbage on idle cycles
      end
   endtask

   task automatic data_frame(input int n, input int h1, input int a1, input int h2, input int a2);
      for (int c = 0; c < N_CH; c++) begin
         if (c == h1)      put(a1, a1);
         else if (c == h2) put(a2, a2);
         else              put(10*n + c + 1, -(c + 2));
      end
   endtask

   task automatic check_pkt(input int base, input int idx);
      for (int b = 0; b < PKT_LEN; b++) begin
         chk(int'(bu[base+b]) == idx, "R5 R9 R7 tuser index", bu[base+b], idx);
         chk(bl[base+b] == (b == PKT_LEN-1), "R7 tlast position", bl[base+b], (b == PKT_LEN-1));
         chk(int'(bi[base+b]) == 10*b + idx + 1, "R6 captured I", bi[base+b], 10*b + idx + 1);
         chk(int'(bq[base+b]) == -(idx + 2), "R6 captured Q", bq[base+b], -(idx + 2));
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R10: outputs quiet in and after reset
      do_reset(3);
      chk(m_tvalid == 1'b0, "R10 tvalid after reset", m_tvalid, 0);
      chk(m_tlast == 1'b0, "R10 tlast after reset", m_tlast, 0);

      // table walk
      for (int e = 0; e < NV; e++) begin
         do_reset(VEC[e][0]);
         bg_frame();
         bg_frame();
         spike_frame(VEC[e][1], VEC[e][2], VEC[e][3], VEC[e][4], 1'b1);
         for (int n = 0; n < PKT_LEN + 2; n++) data_frame(n, -1, 0, -1, 0);
         idle(6);
         if (VEC[e][5] != 0) begin
            chk(nb == PKT_LEN, "R7 R3 packet length", nb, PKT_LEN);
            check_pkt(0, VEC[e][6]);
         end else begin
            chk(nb == 0, "R3 no detection at threshold", nb, 0);
         end
      end

      // R2: first sweep after reset only seeds averages
      do_reset(3);
      spike_frame(3, 1000, -1, 0, 1'b0);
      bg_frame();
      for (int n = 0; n < PKT_LEN + 2; n++) data_frame(n, -1, 0, -1, 0);
      idle(6);
      chk(nb == 0, "R2 seeding sweep gives no packet", nb, 0);

      // R2: 1/16 weight, avg 4096 -> 5888, limit 47104; 153 stays below
      do_reset(3);
      bg_frame();
      spike_frame(2, 128, -1, 0, 1'b0);
      spike_frame(2, 153, -1, 0, 1'b0);
      for (int n = 0; n < PKT_LEN + 2; n++) data_frame(n, -1, 0, -1, 0);
      idle(6);
      chk(nb == 0, "R2 weight: 153 below updated limit", nb, 0);

      // R2: 154 exceeds the updated limit
      do_reset(3);
      bg_frame();
      spike_frame(2, 128, -1, 0, 1'b0);
      spike_frame(2, 154, -1, 0, 1'b0);
      for (int n = 0; n < PKT_LEN + 2; n++) data_frame(n, -1, 0, -1, 0);
      idle(6);
      chk(nb == PKT_LEN, "R2 weight: 154 above updated limit", nb, PKT_LEN);
      if (nb == PKT_LEN) check_pkt(0, 2);

      // R4, R8: averages frozen and no restart during capture
      do_reset(3);
      bg_frame();
      bg_frame();
      spike_frame(3, 129, -1, 0, 1'b0);
      data_frame(0, 5, 128, -1, 0);
      data_frame(1, 5, 128, 6, 1000);   // R8: strong hit while busy
      data_frame(2, 5, 128, -1, 0);
      data_frame(3, -1, 0, -1, 0);
      bg_frame();
      spike_frame(5, 129, -1, 0, 1'b0); // R4: detects only if ch5 average held
      for (int n = 0; n < PKT_LEN + 2; n++) data_frame(n, -1, 0, -1, 0);
      idle(6);
      chk(nb == 2*PKT_LEN, "R4 R8 two packets in total", nb, 2*PKT_LEN);
      if (nb == 2*PKT_LEN) begin
         check_pkt(0, 3);
         check_pkt(PKT_LEN, 5);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule